// File: doc/BRIEF.md
# Floating-Point Status Register Exception Recorder

This block owns a 32-bit floating-point status and control word and keeps its three derived bits honest. An arithmetic unit hands it a vector of freshly detected exception flags; the block ORs them in, marks the sticky any-exception flag, and then rederives the invalid-operation summary and the enabled-exception summary from the individual flags and their enables.

Software reaches the same word through three write forms, all carried on one strobe. The first replaces any set of 4-bit fields selected by an 8-bit mask. The second drops a 4-bit immediate into one field. The third sets or clears a single bit. None of these forms can force the two summary bits, because both are always recomputed. Only the single-bit set may raise the sticky flag implicitly. The top nibble is also exported as a condition copy, and the two rounding-mode bits are exported unchanged.

Neither input has back-pressure: each valid strobe is taken on the clock edge where it is high. When both strobes are high in one cycle, the software write is applied first, the exception flags are ORed on top, and the summaries are derived once from the result.

Top module: `fpsr_recorder`

Bit map (bit 31 is the MSB): 31 any-exception, 30 enabled summary, 29 invalid summary, 28 overflow, 27 underflow, 26 zero-divide, 25 inexact, 24 signalling-NaN invalid, 23 inf-minus-inf, 22 inf-div-inf, 21 zero-div-zero, 20 inf-times-zero, 19 invalid compare, 18..12 result status (stored only), 11 unused, 10 software invalid, 9 invalid square root, 8 invalid convert, 7 invalid enable, 6 overflow enable, 5 underflow enable, 4 zero-divide enable, 3 inexact enable, 2 non-IEEE mode, 1..0 rounding mode.

Field f (0..7) covers bits 31-4f down to 28-4f. Mask bit i selects bits 4i+3..4i, so mask bit 7 is field 0. `sw_op` encoding: 0 = masked field write, 1 = immediate nibble write, 2 = single-bit write, 3 = no change. All three write forms filter out bits 30 and 29 from the value being written.

## Requirements
- R1: After reset, `fpsr_o` is 0.
- R2: An accepted exception vector that is nonzero is ORed into the word and also sets bit 31. The bits it sets stay set until software clears them. An accepted all-zero vector sets nothing.
- R3: After every update, bit 29 is 1 exactly when at least one of bits 24..19, 10, 9 or 8 is 1.
- R4: After every update, bit 30 is 1 exactly when any of these pairs has both bits at 1: 29&7, 28&6, 27&5, 26&4, 25&3.
- R5: Op 0 replaces the fields selected by `sw_mask` with `sw_data`. It leaves the other fields unchanged, and ones in bits 30 and 29 of `sw_data` have no effect.
- R6: Op 0 with `sw_mask[7]` low leaves bit 31 unchanged.
- R7: Op 1 writes `sw_imm` into field `sw_field`. When the field is 0, bit 31 keeps its old value.
- R8: Op 2 addresses bit 31-`sw_bit`. Writing 0 clears that bit. Writing 1 sets that bit and also bit 31, except that a 1 aimed at bit 30 or 29 changes nothing.
- R9: Ops 0 and 1 never set bit 31 implicitly.
- R10: If both strobes are high in one cycle, the software write is applied first, the exception vector is ORed on top, and a single summary derivation follows.
- R11: `cond_o` always equals `fpsr_o[31:28]`, and `rn_o` always equals `fpsr_o[1:0]`.
- R12: In a cycle with neither strobe high, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception vector strobe |
| exc_vec | input | 32 | Newly detected exception flags, laid out as the bit map |
| sw_valid | input | 1 | Software write strobe |
| sw_op | input | 2 | Write form: 0 masked, 1 nibble, 2 bit, 3 none |
| sw_mask | input | 8 | Field select for op 0 |
| sw_data | input | 32 | Data for op 0 |
| sw_field | input | 3 | Target field for op 1 |
| sw_imm | input | 4 | Immediate for op 1 |
| sw_bit | input | 5 | Bit index for op 2, addressing bit 31-index |
| sw_bitval | input | 1 | Value for op 2 |
| fpsr_o | output | 32 | Current status word |
| cond_o | output | 4 | Copy of bits 31..28 |
| rn_o | output | 2 | Rounding-mode bits |

## Verification
The exception path and the software write path can be accepted in the same clock. The bench provokes this with a masked write that clears the underflow field while the arithmetic side reports underflow in the same cycle. It also pairs a rounding-mode write with an inexact report. The expected word comes from a bench model that applies the write first, ORs the flags on top and then derives the summaries. A surviving flag together with a set sticky bit shows that the two were merged in that order.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int FIELD_W  = 4;
  localparam int NFIELDS  = 8;
  localparam int W        = FIELD_W * NFIELDS;

  localparam int B_FX     = 31;
  localparam int B_FEX    = 30;
  localparam int B_VX     = 29;
  localparam int B_OX     = 28;
  localparam int B_UX     = 27;
  localparam int B_ZX     = 26;
  localparam int B_XX     = 25;
  localparam int B_RN_LO  = 0;

  // invalid-operation detail flags feeding the invalid summary
  localparam logic [W-1:0] INV_MASK = 32'h01F8_0700;
  // bits that no write form may force
  localparam logic [W-1:0] DERIVED_MASK = (32'h1 << B_FEX) | (32'h1 << B_VX);

  // flag and enable pairs feeding the enabled summary
  localparam int NPAIRS = 5;
  localparam int FLAG_POS [NPAIRS] = '{29, 28, 27, 26, 25};
  localparam int EN_POS   [NPAIRS] = '{7, 6, 5, 4, 3};

  typedef enum logic [1:0] {
    SW_FIELDS = 2'd0,
    SW_NIBBLE = 2'd1,
    SW_BIT    = 2'd2,
    SW_NONE   = 2'd3
  } sw_op_e;
endpackage

// File: rtl/fpsr_sw_merge.sv
module fpsr_sw_merge
  import fpsr_pkg::*;
(
  input  logic [W-1:0]        cur,
  input  logic                sw_valid,
  input  logic [1:0]          sw_op,
  input  logic [NFIELDS-1:0]  sw_mask,
  input  logic [W-1:0]        sw_data,
  input  logic [2:0]          sw_field,
  input  logic [FIELD_W-1:0]  sw_imm,
  input  logic [4:0]          sw_bit,
  input  logic                sw_bitval,
  output logic [W-1:0]        base,
  output logic [W-1:0]        sw_exc
);
  logic [W-1:0] fmask_raw;
  logic [W-1:0] fmask;
  logic [W-1:0] nmask;
  logic [W-1:0] nval;
  logic [W-1:0] bsel;
  logic [4:0]   nib_lsb;
  logic [4:0]   bit_pos;

  genvar gi;
  generate
    for (gi = 0; gi < NFIELDS; gi++) begin : g_expand
      assign fmask_raw[gi*FIELD_W +: FIELD_W] = {FIELD_W{sw_mask[gi]}};
    end
  endgenerate

  always_comb begin
    fmask = fmask_raw;
    if (!sw_mask[NFIELDS-1]) fmask[B_FX] = 1'b0;

    nib_lsb = 5'd28 - {sw_field, 2'b00};
    nmask   = {{(W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << nib_lsb;
    if (sw_field == 3'd0) nmask[B_FX] = 1'b0;
    nval    = {{(W-FIELD_W){1'b0}}, sw_imm} << nib_lsb;

    bit_pos = 5'd31 - sw_bit;
    bsel    = {{(W-1){1'b0}}, 1'b1} << bit_pos;

    base   = cur;
    sw_exc = '0;
    if (sw_valid) begin
      unique case (sw_op_e'(sw_op))
        SW_FIELDS: base = (cur & ~fmask) | (sw_data & fmask & ~DERIVED_MASK);
        SW_NIBBLE: base = (cur & ~nmask) | (nval & nmask & ~DERIVED_MASK);
        SW_BIT: begin
          base = cur & ~bsel;
          if (sw_bitval) sw_exc = bsel & ~DERIVED_MASK;
        end
        default: base = cur;
      endcase
    end
  end
endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary
  import fpsr_pkg::*;
(
  input  logic [W-1:0] pre,
  input  logic [W-1:0] exc,
  output logic [W-1:0] post
);
  logic [W-1:0] merged;
  logic         inv_any;
  logic [NPAIRS-1:0] hit;

  always_comb begin
    merged = pre & ~DERIVED_MASK;
    if (|exc) merged = merged | exc | (32'h1 << B_FX);
    inv_any = |(merged & INV_MASK);
  end

  genvar gp;
  generate
    for (gp = 0; gp < NPAIRS; gp++) begin : g_pair
      if (FLAG_POS[gp] == B_VX) begin : g_vx
        assign hit[gp] = inv_any & merged[EN_POS[gp]];
      end else begin : g_plain
        assign hit[gp] = merged[FLAG_POS[gp]] & merged[EN_POS[gp]];
      end
    end
  endgenerate

  always_comb begin
    post        = merged;
    post[B_VX]  = inv_any;
    post[B_FEX] = |hit;
  end
endmodule

// File: rtl/fpsr_recorder.sv
module fpsr_recorder
  import fpsr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_valid,
  input  logic [31:0]  exc_vec,
  input  logic         sw_valid,
  input  logic [1:0]   sw_op,
  input  logic [7:0]   sw_mask,
  input  logic [31:0]  sw_data,
  input  logic [2:0]   sw_field,
  input  logic [3:0]   sw_imm,
  input  logic [4:0]   sw_bit,
  input  logic         sw_bitval,
  output logic [31:0]  fpsr_o,
  output logic [3:0]   cond_o,
  output logic [1:0]   rn_o
);
  logic [W-1:0] fpsr_q;
  logic [W-1:0] base;
  logic [W-1:0] sw_exc;
  logic [W-1:0] exc_all;
  logic [W-1:0] next;

  fpsr_sw_merge u_merge (
    .cur      (fpsr_q),
    .sw_valid (sw_valid),
    .sw_op    (sw_op),
    .sw_mask  (sw_mask),
    .sw_data  (sw_data),
    .sw_field (sw_field),
    .sw_imm   (sw_imm),
    .sw_bit   (sw_bit),
    .sw_bitval(sw_bitval),
    .base     (base),
    .sw_exc   (sw_exc)
  );

  assign exc_all = sw_exc | (exc_valid ? exc_vec : '0);

  fpsr_summary u_sum (
    .pre (base),
    .exc (exc_all),
    .post(next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     fpsr_q <= '0;
    else if (exc_valid || sw_valid) fpsr_q <= next;
  end

  assign fpsr_o = fpsr_q;
  assign cond_o = fpsr_q[W-1 -: FIELD_W];
  assign rn_o   = fpsr_q[B_RN_LO +: 2];
endmodule

// File: rtl/fpsr_recorder_chk.sv
module fpsr_recorder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [31:0] exc_vec,
  input logic        sw_valid,
  input logic [31:0] fpsr_o,
  input logic [3:0]  cond_o,
  input logic [1:0]  rn_o
);
  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= seen_rst | !rst_n;

  // R3
  vx_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    fpsr_o[29] == |{fpsr_o[24:19], fpsr_o[10:8]});

  // R4
  fex_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    fpsr_o[30] == ((fpsr_o[29] & fpsr_o[7]) | (fpsr_o[28] & fpsr_o[6]) |
                   (fpsr_o[27] & fpsr_o[5]) | (fpsr_o[26] & fpsr_o[4]) |
                   (fpsr_o[25] & fpsr_o[3])));

  // R11
  cond_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    cond_o == fpsr_o[31:28] && rn_o == fpsr_o[1:0]);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (!exc_valid && !sw_valid) |=> $stable(fpsr_o));

  // R2
  fx_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (exc_valid && exc_vec != 32'h0) |=> fpsr_o[31]);

  // R2
  exc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
    (exc_valid && !sw_valid) |=> ((fpsr_o & ~32'h6000_0000) & ($past(fpsr_o) & ~32'h6000_0000))
                                  == ($past(fpsr_o) & ~32'h6000_0000));
endmodule

bind fpsr_recorder fpsr_recorder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exc_valid(exc_valid),
  .exc_vec  (exc_vec),
  .sw_valid (sw_valid),
  .fpsr_o   (fpsr_o),
  .cond_o   (cond_o),
  .rn_o     (rn_o)
);

// File: tb/fpsr_recorder_bench.sv
module fpsr_recorder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [31:0] exc_vec = '0;
  logic        sw_valid = 1'b0;
  logic [1:0]  sw_op = 2'd3;
  logic [7:0]  sw_mask = '0;
  logic [31:0] sw_data = '0;
  logic [2:0]  sw_field = '0;
  logic [3:0]  sw_imm = '0;
  logic [4:0]  sw_bit = '0;
  logic        sw_bitval = 1'b0;
  logic [31:0] fpsr_o;
  logic [3:0]  cond_o;
  logic [1:0]  rn_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fpsr_recorder u_fpsr_recorder (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_vec(exc_vec),
    .sw_valid(sw_valid), .sw_op(sw_op), .sw_mask(sw_mask), .sw_data(sw_data),
    .sw_field(sw_field), .sw_imm(sw_imm), .sw_bit(sw_bit), .sw_bitval(sw_bitval),
    .fpsr_o(fpsr_o), .cond_o(cond_o), .rn_o(rn_o)
  );

  function automatic logic [31:0] ref_next(
      logic [31:0] cur, logic ev, logic [31:0] e, logic sv, logic [1:0] op,
      logic [7:0] m8, logic [31:0] d, logic [2:0] f, logic [3:0] imm,
      logic [4:0] k, logic v);
    logic [31:0] r, add;
    int top;
    if (!ev && !sv) return cur;
    r = cur; add = '0;
    if (sv) begin
      if (op == 2'd0) begin
        for (int i = 0; i < 32; i++)
          if (m8[i/4] && !(i == 31 && !m8[7]))
            r[i] = (i == 30 || i == 29) ? 1'b0 : d[i];
      end else if (op == 2'd1) begin
        top = 31 - 4*f;
        for (int j = 0; j < 4; j++)
          if (!(top - j == 31 && f == 0))
            r[top-j] = (top - j == 30 || top - j == 29) ? 1'b0 : imm[3-j];
      end else if (op == 2'd2) begin
        r[31-k] = 1'b0;
        if (v && (31 - k) != 30 && (31 - k) != 29) add[31-k] = 1'b1;
      end
    end
    if (ev) add = add | e;
    r[30] = 1'b0; r[29] = 1'b0;
    if (add != 0) begin r = r | add; r[31] = 1'b1; end
    r[29] = r[24] | r[23] | r[22] | r[21] | r[20] | r[19] | r[10] | r[9] | r[8];
    r[30] = (r[29] & r[7]) | (r[28] & r[6]) | (r[27] & r[5]) | (r[26] & r[4]) | (r[25] & r[3]);
    return r;
  endfunction

  task automatic apply(input logic ev, input logic [31:0] e, input logic sv,
                       input logic [1:0] op, input logic [7:0] m8, input logic [31:0] d,
                       input logic [2:0] f, input logic [3:0] imm, input logic [4:0] k,
                       input logic v, input string tag);
    @(negedge clk);
    exc_valid = ev; exc_vec = e; sw_valid = sv; sw_op = op; sw_mask = m8;
    sw_data = d; sw_field = f; sw_imm = imm; sw_bit = k; sw_bitval = v;
    model = ref_next(model, ev, e, sv, op, m8, d, f, imm, k, v);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [31:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (fpsr_o !== ex || cond_o !== ex[31:28] || rn_o !== ex[1:0]) begin
        errors++;
        $display("FAIL %s (R11 views) fpsr=%h cond=%h rn=%h expected fpsr=%h cond=%h rn=%h",
                 t, fpsr_o, cond_o, rn_o, ex, ex[31:28], ex[1:0]);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (fpsr_o !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset fpsr=%h expected %h", fpsr_o, 32'h0);
    end
    // R2: zero-divide flag arrives, sets FX
    apply(1, 32'h0400_0000, 0, 2'd3, 0, 0, 0, 0, 0, 0, "R2 exc sets flag and FX");
    // R7 R4: enable zero-divide via nibble in field 6 -> enabled summary
    apply(0, 0, 1, 2'd1, 0, 0, 3'd6, 4'h1, 0, 0, "R7 R4 nibble enable");
    // R3: signalling-NaN invalid -> invalid summary
    apply(1, 32'h0100_0000, 0, 2'd3, 0, 0, 0, 0, 0, 0, "R3 invalid summary");
    // R2: zero vector accepted, nothing new set
    apply(1, 32'h0, 0, 2'd3, 0, 0, 0, 0, 0, 0, "R2 zero vector");
    // R12: idle cycle holds
    apply(0, 0, 0, 2'd3, 0, 0, 0, 0, 0, 0, "R12 idle hold");
    // R8: clear bit index 0 (bit 31)
    apply(0, 0, 1, 2'd2, 0, 0, 0, 0, 5'd0, 0, "R8 bit clear FX");
    // R5 R6 R9: masked write without top field, all ones
    apply(0, 0, 1, 2'd0, 8'h7F, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 R6 R9 masked write");
    // R5: masked write of everything with zeros
    apply(0, 0, 1, 2'd0, 8'hFF, 32'h0, 0, 0, 0, 0, "R5 full clear");
    // R7 R9: nibble 1111 into field 0 keeps FX, drops summaries
    apply(0, 0, 1, 2'd1, 0, 0, 3'd0, 4'hF, 0, 0, "R7 R9 field0 nibble");
    // R8: set bit index 5 (bit 26) raises FX
    apply(0, 0, 1, 2'd2, 0, 0, 0, 0, 5'd5, 1, "R8 bit set ZX");
    // R8: set aimed at bit 30 is filtered
    apply(0, 0, 1, 2'd2, 0, 0, 0, 0, 5'd1, 1, "R8 bit set on summary filtered");
    // R6: masked write of top field with FX writes FX
    apply(0, 0, 1, 2'd0, 8'h80, 32'h0000_0000, 0, 0, 0, 0, "R6 top field clears FX");
    // R10 R11: rounding-mode write plus inexact report
    apply(1, 32'h0200_0000, 1, 2'd0, 8'h01, 32'h0000_000B, 0, 0, 0, 0, "R10 R11 rn write with XX");
    // R10: clear underflow field while underflow is reported
    apply(1, 32'h0800_0000, 1, 2'd0, 8'h40, 32'h0, 0, 0, 0, 0, "R10 same-cycle clear vs flag");
    // R4: underflow enable via bit index 26 (bit 5)
    apply(0, 0, 1, 2'd2, 0, 0, 0, 0, 5'd26, 1, "R4 R8 UE bit set");
    // R3: invalid convert via nibble field 5 (bits 11..8)
    apply(0, 0, 1, 2'd1, 0, 0, 3'd5, 4'h1, 0, 0, "R3 R7 invalid convert nibble");
    // R4: invalid enable via field 6 nibble 8
    apply(0, 0, 1, 2'd1, 0, 0, 3'd6, 4'h8, 0, 0, "R4 invalid enable");
    // R3: clear invalid convert, summary drops
    apply(0, 0, 1, 2'd2, 0, 0, 0, 0, 5'd23, 0, "R3 R8 invalid cleared");
    apply(0, 0, 0, 2'd3, 0, 0, 0, 0, 0, 0, "R12 final hold");
    @(negedge clk);
    exc_valid = 0; sw_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule